// File: doc/BRIEF.md
# PCI Host Bridge Configuration Register File

This block is the small configuration register space of a PCI host bridge. Software reaches it through a byte-wide port: a byte offset, write data, a write strobe and a read data bus. Reads are combinational from the offset. Writes take effect at the clock edge where the strobe is high. The block holds a status flag that records data parity errors, fixed identification bytes, a latency timer setting and a bridge control byte. The timer and the control bits are driven out to the bus logic.

The bus interface supplies three event qualifiers every cycle:
- a parity error was driven or seen,
- this bridge was master of the cycle,
- parity error response is enabled in the command register.

The parity flag is set only when all three are true in the same cycle. Software clears the flag by writing a one to it.

Top module: `pcib_cfg_regs`

## Requirements
- R1: When `perr_seen`, `is_master` and `perr_resp_en` are all 1 in one cycle, the parity flag (bit 0 of offset 07h) reads 1 from the next cycle on.
- R2: If any one of the three qualifiers is 0, the parity flag does not set.
- R3: Writing offset 07h with bit 0 = 1 clears the parity flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R4: A set condition and a clearing write in the same cycle leave the parity flag at 1.
- R5: Offset 06h reads 80h: bit 7 (fast back-to-back capable) is always 1 and the other bits are 0. Writes to 06h have no effect.
- R6: The identification bytes read fixed values and ignore writes:
  - offset 08h (revision) reads 00h,
  - offsets 09h and 0Ah read 00h,
  - offset 0Bh reads 06h (class code 060000h),
  - offset 0Ch (cache line size) reads 00h.
- R7: Offset 0Dh (latency timer) stores write data bits 4:0. Bits 7:5 read 0. The stored value drives `lat_timer`.
- R8: Offset 40h (control) stores write data bits 6:1. Bits 7 and 0 read 0. The outputs map as follows:
  - bit 6 to `single_wr`,
  - bit 5 to `single_rd`,
  - bit 4 to `retry_wbuf`,
  - bit 3 to `slv_wbuf_en`,
  - bit 2 to `line_rd_en`,
  - bit 1 to `burst_wr_en`.
- R9: Offsets 0Eh through 3Fh read 00h, even after writes to them.
- R10: Reset (`rst_n` low) returns the parity flag, the latency timer and the control byte to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| perr_seen | input | 1 | Parity error driven or observed this cycle |
| is_master | input | 1 | Bridge is master of the current cycle |
| perr_resp_en | input | 1 | Parity error response enabled |
| lat_timer | output | 5 | Latency timer setting |
| single_wr | output | 1 | Disconnect after the first write data phase |
| single_rd | output | 1 | Disconnect after the first read data phase |
| retry_wbuf | output | 1 | Retry target cycles while the master write buffers hold data |
| slv_wbuf_en | output | 1 | Target write buffer enable |
| line_rd_en | output | 1 | Inbound reads fetch a full cache line |
| burst_wr_en | output | 1 | Burst on write-and-invalidate from an external master |

## Verification
The assertions assume the three event qualifiers and the port inputs are stable across each clock edge and known once reset is released. The assertions also assume software reads are not made in the same cycle as a write to the same offset. The bench changes every input only just after a rising edge and holds it for a full cycle. The bench issues reads in their own cycles, so each comparison sees settled state.

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs #(
  parameter int          AW         = 8,
  parameter int          LATW       = 5,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          cfg_wr,
  output logic [7:0]    cfg_rdata,
  input  logic          perr_seen,
  input  logic          is_master,
  input  logic          perr_resp_en,
  output logic [LATW-1:0] lat_timer,
  output logic          single_wr,
  output logic          single_rd,
  output logic          retry_wbuf,
  output logic          slv_wbuf_en,
  output logic          line_rd_en,
  output logic          burst_wr_en
);
  localparam logic [AW-1:0] A_STAT_LO = AW'(8'h06);
  localparam logic [AW-1:0] A_STAT_HI = AW'(8'h07);
  localparam logic [AW-1:0] A_REV     = AW'(8'h08);
  localparam logic [AW-1:0] A_CLS0    = AW'(8'h09);
  localparam logic [AW-1:0] A_CLS1    = AW'(8'h0A);
  localparam logic [AW-1:0] A_CLS2    = AW'(8'h0B);
  localparam logic [AW-1:0] A_CLSZ    = AW'(8'h0C);
  localparam logic [AW-1:0] A_LAT     = AW'(8'h0D);
  localparam logic [AW-1:0] A_CTL     = AW'(8'h40);

  logic            par_flag;
  logic [LATW-1:0] lat_q;
  logic [5:0]      ctl_q;

  wire par_hit = perr_seen & is_master & perr_resp_en;
  wire wr_stat = cfg_wr && cfg_addr == A_STAT_HI;
  wire wr_lat  = cfg_wr && cfg_addr == A_LAT;
  wire wr_ctl  = cfg_wr && cfg_addr == A_CTL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_flag <= 1'b0;
      lat_q    <= '0;
      ctl_q    <= '0;
    end else begin
      if (par_hit)                      par_flag <= 1'b1;
      else if (wr_stat && cfg_wdata[0]) par_flag <= 1'b0;
      if (wr_lat) lat_q <= cfg_wdata[LATW-1:0];
      if (wr_ctl) ctl_q <= cfg_wdata[6:1];
    end
  end

  always_comb begin
    case (cfg_addr)
      A_STAT_LO: cfg_rdata = 8'h80;
      A_STAT_HI: cfg_rdata = {7'd0, par_flag};
      A_REV:     cfg_rdata = REV_ID;
      A_CLS0:    cfg_rdata = CLASS_CODE[7:0];
      A_CLS1:    cfg_rdata = CLASS_CODE[15:8];
      A_CLS2:    cfg_rdata = CLASS_CODE[23:16];
      A_CLSZ:    cfg_rdata = 8'h00;
      A_LAT:     cfg_rdata = 8'(lat_q);
      A_CTL:     cfg_rdata = {1'b0, ctl_q, 1'b0};
      default:   cfg_rdata = 8'h00;
    endcase
  end

  assign lat_timer   = lat_q;
  assign single_wr   = ctl_q[5];
  assign single_rd   = ctl_q[4];
  assign retry_wbuf  = ctl_q[3];
  assign slv_wbuf_en = ctl_q[2];
  assign line_rd_en  = ctl_q[1];
  assign burst_wr_en = ctl_q[0];

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_seen && is_master && perr_resp_en) |=> par_flag);

  p_only_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(perr_seen && is_master && perr_resp_en) && !par_flag) |=> !par_flag);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == A_STAT_HI && cfg_wdata[0] && !(perr_seen && is_master && perr_resp_en))
    |=> (cfg_rdata[0] == 1'b0 || cfg_addr != A_STAT_HI));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (par_flag && !(cfg_wr && cfg_addr == A_STAT_HI && cfg_wdata[0])) |=> par_flag);

  p_fbb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == A_STAT_LO) |-> cfg_rdata == 8'h80);

  p_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == A_LAT) |=> lat_timer == $past(cfg_wdata[LATW-1:0]));

  p_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == A_CTL) |=>
      {single_wr, single_rd, retry_wbuf, slv_wbuf_en, line_rd_en, burst_wr_en} == $past(cfg_wdata[6:1]));

  p_resv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= AW'(8'h0E) && cfg_addr <= AW'(8'h3F)) |-> cfg_rdata == 8'h00);
endmodule

// File: tb/pcib_cfg_regs_test.sv
module pcib_cfg_regs_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic cfg_wr = 0, perr_seen = 0, is_master = 0, perr_resp_en = 0;
  logic [7:0] cfg_rdata;
  logic [4:0] lat_timer;
  logic single_wr, single_rd, retry_wbuf, slv_wbuf_en, line_rd_en, burst_wr_en;

  int total = 0, bad = 0;
  logic rd_pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pcib_cfg_regs uut (.*);

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic e, input logic m, input logic en);
    @(posedge clk); #1;
    rd_pend = 0; cfg_wr = w; cfg_addr = a; cfg_wdata = d;
    perr_seen = e; is_master = m; perr_resp_en = en;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    step(0, a, 0, 0, 0, 0);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_pend = 1;
  endtask

  always @(negedge clk) if (rd_pend && exp_q.size() > 0) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    total++;
    if (cfg_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", t, cfg_addr, cfg_rdata, e);
    end
  end

  task automatic chk_out(input logic [10:0] e, input string t);
    logic [10:0] a;
    step(0, 8'h00, 0, 0, 0, 0); #1;
    a = {lat_timer, single_wr, single_rd, retry_wbuf, slv_wbuf_en, line_rd_en, burst_wr_en};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s outputs actual=%h expected=%h", t, a, e);
    end
  endtask

  initial begin
    #(8*200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h07, 8'h00, "R10 parity");
    rd(8'h0D, 8'h00, "R10 lat");
    rd(8'h40, 8'h00, "R10 ctl");
    chk_out(11'h000, "R10 outputs");
    // latency timer
    wr(8'h0D, 8'hFF); rd(8'h0D, 8'h1F, "R7 upper zero");
    chk_out({5'h1F, 6'h00}, "R7 lat out");
    wr(8'h0D, 8'hAA); rd(8'h0D, 8'h0A, "R7 pattern");
    // control
    wr(8'h40, 8'hFF); rd(8'h40, 8'h7E, "R8 reserved bits");
    chk_out({5'h0A, 6'h3F}, "R8 all set");
    wr(8'h40, 8'h54); rd(8'h40, 8'h54, "R8 pattern");
    chk_out({5'h0A, 6'b101010}, "R8 mapping");
    wr(8'h40, 8'h0B); rd(8'h40, 8'h0A, "R8 bit0 dropped");
    chk_out({5'h0A, 6'b000101}, "R8 mapping low");
    // identification
    for (int i = 8; i <= 12; i++) wr(8'(i), 8'hFF);
    rd(8'h08, 8'h00, "R6 revision");
    rd(8'h09, 8'h00, "R6 class lo");
    rd(8'h0A, 8'h00, "R6 class mid");
    rd(8'h0B, 8'h06, "R6 class hi");
    rd(8'h0C, 8'h00, "R6 line size");
    wr(8'h06, 8'h00); rd(8'h06, 8'h80, "R5 fast b2b");
    wr(8'h06, 8'hFF); rd(8'h06, 8'h80, "R5 write ignored");
    // reserved space
    wr(8'h0E, 8'hFF); wr(8'h20, 8'h5A); wr(8'h3F, 8'hFF);
    rd(8'h0E, 8'h00, "R9 low end");
    rd(8'h20, 8'h00, "R9 middle");
    rd(8'h3F, 8'h00, "R9 high end");
    // parity flag qualifiers
    step(0, 8'h00, 0, 1, 0, 1); rd(8'h07, 8'h00, "R2 not master");
    step(0, 8'h00, 0, 1, 1, 0); rd(8'h07, 8'h00, "R2 response off");
    step(0, 8'h00, 0, 0, 1, 1); rd(8'h07, 8'h00, "R2 no error");
    step(0, 8'h00, 0, 1, 1, 1); rd(8'h07, 8'h01, "R1 set");
    rd(8'h07, 8'h01, "R1 held");
    wr(8'h07, 8'hFE); rd(8'h07, 8'h01, "R3 write zero keeps");
    wr(8'h07, 8'h01); rd(8'h07, 8'h00, "R3 write one clears");
    step(0, 8'h00, 0, 1, 1, 1);
    step(1, 8'h07, 8'h01, 1, 1, 1); rd(8'h07, 8'h01, "R4 set wins");
    step(1, 8'h07, 8'h01, 0, 1, 1); rd(8'h07, 8'h00, "R4 later clear");
    // reset restores defaults
    step(0, 8'h00, 0, 1, 1, 1);
    wr(8'h0D, 8'h13); wr(8'h40, 8'h7E);
    step(0, 8'h00, 0, 0, 0, 0); rst_n = 0;
    step(0, 8'h00, 0, 0, 0, 0); rst_n = 1;
    rd(8'h07, 8'h00, "R10 parity after reset");
    rd(8'h0D, 8'h00, "R10 lat after reset");
    rd(8'h40, 8'h00, "R10 ctl after reset");
    chk_out(11'h000, "R10 outputs after reset");
    step(0, 8'h00, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule